// File: doc/BRIEF.md
# Dual-Core Debug Cross-Trigger Router

This block carries debug events between two processor cores. Each core owns one trigger node. A node takes the core's trigger inputs, for example a "core has halted" level, and raises trigger outputs such as a halt request or a restart request. A small shared channel fabric joins the two nodes. Every channel event raised at either node is ORed onto the fabric, so both cores see it in the same clock cycle.

Inside a node, one routing mask per trigger input chooses which channels a rising edge on that input drives. One routing mask per trigger output chooses which active channels set that output. A set output stays high until software clears it. Software reaches each node through its own word-addressed register port with a valid strobe. Through that port it can program the masks, inject channel pulses directly, clear latched outputs and read back the state. A typical sequence is a cross-halt: one core halts, the event travels on channel 0 and a halt request appears at the other core. After that, both nodes are acknowledged and a pulse on channel 1 restarts both cores together.

Top module: `xtrig_router`

Register word map of each node, with the default of 8 triggers:

| Word address | Access | Contents |
|---|---|---|
| 0..7 | read/write | input routing mask for trigger input i, bit n = channel n |
| 8..15 | read/write | output routing mask for trigger output i−8, bit n = channel n |
| 16 | write, reads 0 | channel pulse: bit n pulses channel n for one cycle |
| 17 | write, reads 0 | acknowledge: bit i clears latched output i |
| 18 | read | latched trigger outputs, bit i = output i |

## Requirements
- R1: After reset, every routing mask reads 0, every trigger output is low and the status word (address 18) reads 0.
- R2: A write to a routing mask keeps only its low 4 bits, and a read returns them. Read data appears on the node's read-data port one clock after the valid read request. Reads of the pulse (16) and acknowledge (17) addresses return 0.
- R3: A rising edge on trigger input i drives, for one cycle, every channel n whose bit n is set in input mask i. An input held high produces a single event. A mask with several bits set drives several channels at once.
- R4: Trigger output i becomes high on the clock edge that follows a cycle in which any channel set in its output mask is active. The output is not set in any other way.
- R5: Writing a value to the pulse address activates, for one cycle, every channel whose bit is set. 0x01 drives channel 0 and 0x02 drives channel 1.
- R6: A channel event raised at either node reaches the outputs of both nodes on the same clock edge.
- R7: A set output stays high until a write to the acknowledge address of its own node has bit i set to 1. Writing 0 to the acknowledge address changes nothing.
- R8: If an acknowledge of output i and a new hit on output i fall in the same cycle, the output stays high.
- R9: With input 0 of node 0 routed to channel 0 and output 0 of node 1 routed from channel 0, a rise on node 0 input 0 raises node 1 output 0 one clock later. Node 0's own outputs stay low.
- R10: A read of the status address returns the trigger outputs of that node as they were in the cycle of the request.
- R11: With all masks at zero, a trigger input edge changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_valid | input | 2 | Register request strobe, one bit per node |
| cfg_write | input | 2 | 1 = write, 0 = read, per node |
| cfg_addr | input | 2×5 | Word address, per node |
| cfg_wdata | input | 2×8 | Write data, per node |
| cfg_rdata | output | 2×8 | Registered read data, per node |
| trig_in | input | 2×8 | Trigger inputs of each core |
| trig_out | output | 2×8 | Latched trigger outputs of each core |

## Verification
The hardest case is the collision in R8. An acknowledge must clear an output in exactly the cycle that a new channel hit sets it again. From the ports, this needs two independent register ports driven on the same edge. The bench drives the acknowledge write on node 1 and a channel pulse write on node 0 in the same cycle, then checks that the output survives. A second hard case is the single-event rule for a held input. The bench acknowledges the output while the input stays high, holds it for several more cycles, and only then releases the input and raises it again.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;

    typedef enum logic [2:0] {
        RK_IN_MASK,
        RK_OUT_MASK,
        RK_PULSE,
        RK_ACK,
        RK_STATUS,
        RK_NONE
    } reg_kind_e;

    function automatic int pulse_addr(input int ntrig);
        return 2 * ntrig;
    endfunction

    function automatic int ack_addr(input int ntrig);
        return 2 * ntrig + 1;
    endfunction

    function automatic int status_addr(input int ntrig);
        return 2 * ntrig + 2;
    endfunction

    function automatic reg_kind_e reg_kind(input int addr, input int ntrig);
        if (addr < ntrig)                    return RK_IN_MASK;
        else if (addr < 2 * ntrig)           return RK_OUT_MASK;
        else if (addr == pulse_addr(ntrig))  return RK_PULSE;
        else if (addr == ack_addr(ntrig))    return RK_ACK;
        else if (addr == status_addr(ntrig)) return RK_STATUS;
        return RK_NONE;
    endfunction

    function automatic int reg_index(input int addr, input int ntrig);
        return (addr < ntrig) ? addr : addr - ntrig;
    endfunction

endpackage

// File: rtl/xtrig_matrix.sv
module xtrig_matrix #(
    parameter int NUM_NODES = 2,
    parameter int NUM_CH    = 4
) (
    input  logic [NUM_NODES-1:0][NUM_CH-1:0] node_event,
    output logic [NUM_CH-1:0]                chan_active
);

    always_comb begin
        chan_active = '0;
        for (int k = 0; k < NUM_NODES; k++) begin
            chan_active = chan_active | node_event[k];
        end
    end

endmodule

// File: rtl/xtrig_node.sv
module xtrig_node #(
    parameter int NUM_CH   = 4,
    parameter int NUM_TRIG = 8,
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_valid,
    input  logic                cfg_write,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output logic [DATA_W-1:0]   cfg_rdata,
    input  logic [NUM_TRIG-1:0] trig_in,
    output logic [NUM_CH-1:0]   chan_event,
    input  logic [NUM_CH-1:0]   chan_active,
    output logic [NUM_TRIG-1:0] trig_out
);
    import xtrig_pkg::*;

    typedef struct packed {
        logic [NUM_TRIG-1:0][NUM_CH-1:0] in_mask;
        logic [NUM_TRIG-1:0][NUM_CH-1:0] out_mask;
        logic [NUM_TRIG-1:0]             prev;
        logic [NUM_TRIG-1:0]             latch;
        logic [DATA_W-1:0]               rdata;
    } node_state_t;

    localparam node_state_t ST_RESET = '{
        in_mask:  '0,
        out_mask: '0,
        prev:     '1,
        latch:    '0,
        rdata:    '0
    };

    node_state_t st_d, st_q;

    reg_kind_e           kind;
    int                  idx;
    logic                is_wr;
    logic                is_rd;
    logic [NUM_CH-1:0]   pulse_vec;
    logic [NUM_TRIG-1:0] ack_vec;
    logic [NUM_TRIG-1:0] rise;
    logic [NUM_TRIG-1:0] hit;

    // request decode and locally raised channel events
    always_comb begin
        kind      = reg_kind(int'(cfg_addr), NUM_TRIG);
        idx       = reg_index(int'(cfg_addr), NUM_TRIG);
        is_wr     = cfg_valid && cfg_write;
        is_rd     = cfg_valid && !cfg_write;
        pulse_vec = (is_wr && kind == RK_PULSE) ? cfg_wdata[NUM_CH-1:0] : '0;
        ack_vec   = (is_wr && kind == RK_ACK) ? cfg_wdata[NUM_TRIG-1:0] : '0;
        rise      = trig_in & ~st_q.prev;
        chan_event = pulse_vec;
        for (int i = 0; i < NUM_TRIG; i++) begin
            if (rise[i]) chan_event = chan_event | st_q.in_mask[i];
        end
    end

    // next state
    always_comb begin
        st_d      = st_q;
        st_d.prev = trig_in;

        for (int i = 0; i < NUM_TRIG; i++) begin
            hit[i] = |(chan_active & st_q.out_mask[i]);
        end
        // a new hit wins over an acknowledge in the same cycle
        st_d.latch = (st_q.latch & ~ack_vec) | hit;

        if (is_wr) begin
            for (int i = 0; i < NUM_TRIG; i++) begin
                if (idx == i && kind == RK_IN_MASK)
                    st_d.in_mask[i] = cfg_wdata[NUM_CH-1:0];
                if (idx == i && kind == RK_OUT_MASK)
                    st_d.out_mask[i] = cfg_wdata[NUM_CH-1:0];
            end
        end

        if (is_rd) begin
            st_d.rdata = '0;
            for (int i = 0; i < NUM_TRIG; i++) begin
                if (idx == i && kind == RK_IN_MASK)
                    st_d.rdata[NUM_CH-1:0] = st_q.in_mask[i];
                if (idx == i && kind == RK_OUT_MASK)
                    st_d.rdata[NUM_CH-1:0] = st_q.out_mask[i];
            end
            if (kind == RK_STATUS)
                st_d.rdata[NUM_TRIG-1:0] = st_q.latch;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign trig_out  = st_q.latch;
    assign cfg_rdata = st_q.rdata;

endmodule

// File: rtl/xtrig_router.sv
module xtrig_router #(
    parameter int  NUM_CH   = 4,
    parameter int  NUM_TRIG = 8,
    localparam int ADDR_W   = $clog2(2 * NUM_TRIG + 3),
    localparam int DATA_W   = (NUM_TRIG > NUM_CH) ? NUM_TRIG : NUM_CH
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    cfg_valid,
    input  logic [1:0]                    cfg_write,
    input  logic [1:0][ADDR_W-1:0]        cfg_addr,
    input  logic [1:0][DATA_W-1:0]        cfg_wdata,
    output logic [1:0][DATA_W-1:0]        cfg_rdata,
    input  logic [1:0][NUM_TRIG-1:0]      trig_in,
    output logic [1:0][NUM_TRIG-1:0]      trig_out
);
    localparam int NUM_NODES = 2;

    logic [NUM_NODES-1:0][NUM_CH-1:0] node_event;
    logic [NUM_CH-1:0]                chan_active;

    xtrig_matrix #(
        .NUM_NODES (NUM_NODES),
        .NUM_CH    (NUM_CH)
    ) matrix_i (
        .node_event  (node_event),
        .chan_active (chan_active)
    );

    for (genvar c = 0; c < NUM_NODES; c++) begin : g_node
        xtrig_node #(
            .NUM_CH   (NUM_CH),
            .NUM_TRIG (NUM_TRIG),
            .ADDR_W   (ADDR_W),
            .DATA_W   (DATA_W)
        ) node_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .cfg_valid   (cfg_valid[c]),
            .cfg_write   (cfg_write[c]),
            .cfg_addr    (cfg_addr[c]),
            .cfg_wdata   (cfg_wdata[c]),
            .cfg_rdata   (cfg_rdata[c]),
            .trig_in     (trig_in[c]),
            .chan_event  (node_event[c]),
            .chan_active (chan_active),
            .trig_out    (trig_out[c])
        );
    end

endmodule

// File: rtl/xtrig_router_chk.sv
module xtrig_router_chk #(
    parameter int  NUM_CH   = 4,
    parameter int  NUM_TRIG = 8,
    localparam int ADDR_W   = $clog2(2 * NUM_TRIG + 3),
    localparam int DATA_W   = (NUM_TRIG > NUM_CH) ? NUM_TRIG : NUM_CH
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [1:0]               cfg_valid,
    input logic [1:0]               cfg_write,
    input logic [1:0][ADDR_W-1:0]   cfg_addr,
    input logic [1:0][DATA_W-1:0]   cfg_wdata,
    input logic [1:0][DATA_W-1:0]   cfg_rdata,
    input logic [1:0][NUM_TRIG-1:0] trig_in,
    input logic [1:0][NUM_TRIG-1:0] trig_out
);
    import xtrig_pkg::*;

    localparam int PULSE_A  = pulse_addr(NUM_TRIG);
    localparam int ACK_A    = ack_addr(NUM_TRIG);
    localparam int STATUS_A = status_addr(NUM_TRIG);

    logic pulse_any;
    always_comb begin
        pulse_any = 1'b0;
        for (int c = 0; c < 2; c++) begin
            if (cfg_valid[c] && cfg_write[c] && int'(cfg_addr[c]) == PULSE_A)
                pulse_any = 1'b1;
        end
    end

    for (genvar c = 0; c < 2; c++) begin : g_n
        p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> trig_out[c] == '0);

        p_pulse_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_valid[c] && !cfg_write[c] && int'(cfg_addr[c]) == PULSE_A)
            |=> cfg_rdata[c] == '0);

        p_status_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_valid[c] && !cfg_write[c] && int'(cfg_addr[c]) == STATUS_A)
            |=> cfg_rdata[c][NUM_TRIG-1:0] == $past(trig_out[c]));

        for (genvar j = 0; j < NUM_TRIG; j++) begin : g_t
            p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (trig_out[c][j] && !(cfg_valid[c] && cfg_write[c] &&
                 int'(cfg_addr[c]) == ACK_A && cfg_wdata[c][j]))
                |=> trig_out[c][j]);

            p_set_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(trig_out[c][j]) |->
                    ($past(pulse_any) ||
                     (|($past(trig_in[0]) & ~$past(trig_in[0], 2))) ||
                     (|($past(trig_in[1]) & ~$past(trig_in[1], 2)))));
        end
    end

endmodule

bind xtrig_router xtrig_router_chk #(
    .NUM_CH   (NUM_CH),
    .NUM_TRIG (NUM_TRIG)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_valid (cfg_valid),
    .cfg_write (cfg_write),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .trig_in   (trig_in),
    .trig_out  (trig_out)
);

// File: tb/xtrig_router_tb.sv
module xtrig_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 8;
    localparam int AW = 5;
    localparam int DW = 8;
    localparam int A_PULSE = 16;
    localparam int A_ACK = 17;
    localparam int A_STATUS = 18;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [1:0]         cfg_valid = '0;
    logic [1:0]         cfg_write = '0;
    logic [1:0][AW-1:0] cfg_addr = '0;
    logic [1:0][DW-1:0] cfg_wdata = '0;
    logic [1:0][DW-1:0] cfg_rdata;
    logic [1:0][NT-1:0] trig_in = '0;
    logic [1:0][NT-1:0] trig_out;

    int n_tests = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xtrig_router dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .trig_in(trig_in), .trig_out(trig_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int c, input int a, input int d);
        @(negedge clk);
        cfg_valid[c] = 1'b1; cfg_write[c] = 1'b1;
        cfg_addr[c] = AW'(a); cfg_wdata[c] = DW'(d);
        @(negedge clk);
        cfg_valid[c] = 1'b0; cfg_write[c] = 1'b0;
    endtask

    task automatic rd(input int c, input int a, output int d);
        @(negedge clk);
        cfg_valid[c] = 1'b1; cfg_write[c] = 1'b0; cfg_addr[c] = AW'(a);
        @(negedge clk);
        d = int'(cfg_rdata[c]);
        cfg_valid[c] = 1'b0;
    endtask

    task automatic set_trig(input int c, input int j, input bit v);
        @(negedge clk);
        trig_in[c][j] = v;
        @(negedge clk);
    endtask

    task automatic clear_all();
        wr(0, A_ACK, 8'hFF);
        wr(1, A_ACK, 8'hFF);
    endtask

    task automatic t_reset();
        int d;
        check(trig_out == '0, "R1 outputs after reset", int'(trig_out), 0);
        rd(0, 0, d);  check(d == 0, "R1 input mask 0", d, 0);
        rd(1, 15, d); check(d == 0, "R1 output mask 7", d, 0);
        rd(0, A_STATUS, d); check(d == 0, "R1 status", d, 0);
    endtask

    task automatic t_regs();
        int d;
        wr(0, 3, 8'hF5);
        rd(0, 3, d); check(d == 5, "R2 input mask keeps low bits", d, 5);
        wr(1, 13, 8'h06);
        rd(1, 13, d); check(d == 6, "R2 output mask readback", d, 6);
        rd(1, A_PULSE, d); check(d == 0, "R2 pulse reads zero", d, 0);
        wr(0, 3, 0);
        wr(1, 13, 0);
    endtask

    task automatic t_halt_route();
        int d;
        wr(0, 0, 8'h01);
        wr(1, 8, 8'h01);
        set_trig(0, 0, 1'b1);
        check(trig_out[1][0] == 1'b1, "R9 halt reaches node 1", int'(trig_out[1]), 1);
        check(trig_out[0] == '0, "R9 node 0 stays quiet", int'(trig_out[0]), 0);
        rd(1, A_STATUS, d); check(d == 1, "R10 status of node 1", d, 1);
    endtask

    task automatic t_ack();
        wr(1, A_ACK, 8'h00);
        check(trig_out[1][0] == 1'b1, "R7 ack of 0 has no effect", int'(trig_out[1]), 1);
        wr(1, A_ACK, 8'h01);
        check(trig_out[1][0] == 1'b0, "R7 ack of 1 clears", int'(trig_out[1]), 0);
        wr(1, A_ACK, 8'h00);
        repeat (3) @(negedge clk);
        check(trig_out[1][0] == 1'b0, "R3 held input gives one event", int'(trig_out[1]), 0);
        set_trig(0, 0, 1'b0);
        set_trig(0, 0, 1'b1);
        check(trig_out[1][0] == 1'b1, "R3 new edge gives new event", int'(trig_out[1]), 1);
        set_trig(0, 0, 1'b0);
        clear_all();
    endtask

    task automatic t_pulse();
        wr(0, 8, 8'h01);
        wr(0, 9, 8'h02);
        wr(1, 9, 8'h02);
        wr(0, A_PULSE, 8'h01);
        check(trig_out[0] == 8'h01, "R5 pulse ch0 node 0", int'(trig_out[0]), 1);
        check(trig_out[1] == 8'h01, "R6 pulse ch0 node 1 same edge", int'(trig_out[1]), 1);
        clear_all();
        wr(1, A_PULSE, 8'h02);
        check(trig_out[0] == 8'h02, "R6 pulse from node 1 reaches node 0", int'(trig_out[0]), 2);
        check(trig_out[1] == 8'h02, "R5 pulse ch1 node 1", int'(trig_out[1]), 2);
        clear_all();
        check(trig_out == '0, "R7 both nodes acknowledged", int'(trig_out), 0);
    endtask

    task automatic t_multi_channel();
        wr(1, 2, 8'h03);
        set_trig(1, 2, 1'b1);
        check(trig_out[0] == 8'h03, "R3 two channels from one input", int'(trig_out[0]), 3);
        check(trig_out[1] == 8'h03, "R4 node 1 masks see both channels", int'(trig_out[1]), 3);
        set_trig(1, 2, 1'b0);
        wr(1, 2, 8'h00);
        clear_all();
    endtask

    task automatic t_collision();
        wr(0, A_PULSE, 8'h01);
        @(negedge clk);
        cfg_valid = 2'b11; cfg_write = 2'b11;
        cfg_addr[0] = AW'(A_PULSE); cfg_wdata[0] = 8'h01;
        cfg_addr[1] = AW'(A_ACK);   cfg_wdata[1] = 8'h01;
        @(negedge clk);
        cfg_valid = 2'b00; cfg_write = 2'b00;
        check(trig_out[1][0] == 1'b1, "R8 hit wins over ack", int'(trig_out[1]), 1);
        clear_all();
        check(trig_out == '0, "R7 cleared after collision", int'(trig_out), 0);
    endtask

    task automatic t_no_route();
        set_trig(0, 5, 1'b1);
        @(negedge clk);
        check(trig_out == '0, "R11 unrouted input", int'(trig_out), 0);
        set_trig(0, 5, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_no_route();
        t_halt_route();
        t_ack();
        t_pulse();
        t_multi_channel();
        t_collision();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule